// File: doc/BRIEF.md
# Instruction Breakpoint and Step Counter

This block sits beside the issue stage of a processor core and watches each instruction as it issues. It is given the instruction's program counter, the current interrupt level and two decoded flags that mark a software break instruction. It holds a small set of instruction-address breakpoint registers with a per-breakpoint enable mask, plus an instruction step counter and a counter level register. All of these are written, and can be read back, through a special-register port.

For every issued instruction the block decides whether a debug event should be raised and which cause to report. A counter event comes first, then an address breakpoint, then the software break flags. The counter advances by one for each instruction that issues while the current interrupt level is below the counter level. Instead of wrapping to zero it holds its value and raises a counter event. Events are only raised when debugging is allowed and the current interrupt level is below a fixed debug level. The result is registered and appears on the event outputs one clock after the issue cycle. Taking the exception itself is left to the core.

Top module: `ibsc_top`

## Requirements
- R1: After reset the enable mask, the counter and the counter level all read as zero, and `evt_valid` is low.
- R2: A write to the enable register (select 0) keeps only the low NUM_BP bits. The upper bits read back as zero.
- R3: A write to the counter level register (select 2) keeps only its low 4 bits.
- R4: The breakpoint registers use selects 4 and up, one per breakpoint. A breakpoint fires when its enable bit is set and its address equals `issue_pc`. The event has cause 0x02, and `evt_index` gives the lowest matching index. The event appears one clock after the issue cycle.
- R5: A breakpoint whose enable bit is clear never fires, even when its address matches.
- R6: The counter (select 1) adds one for each issued instruction while `issue_level` is below the counter level. Otherwise it is unchanged.
- R7: When adding one would wrap the counter to zero, the counter keeps its value and an event with cause 0x01 is raised.
- R8: No event is raised unless `dbg_allow` is high and `issue_level` is below DEBUG_LEVEL (default 6). The counter still advances or holds as in R6 and R7.
- R9: Exactly one cause bit is set per event. The priority is counter (0x01) over breakpoint (0x02) over wide software break (0x08) over narrow software break (0x10). A breakpoint on a break instruction reports 0x02.
- R10: A software write to the counter in the same cycle as an issuing instruction takes effect for the next instruction. The writing instruction itself is not counted and raises no counter event.
- R11: With the counter preset to 0xFFFFFFFE and the counter level set to 1, instructions issued at level 0 raise the counter event on the second instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sr_wr_en | input | 1 | Special-register write strobe |
| sr_wr_sel | input | 3 | Register select for the write: 0 enable, 1 counter, 2 counter level, 4+i breakpoint address i |
| sr_wr_data | input | DW | Write data |
| sr_rd_sel | input | 3 | Register select for the read, same encoding as the write select |
| sr_rd_data | output | DW | Read data, zero-extended |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_pc | input | DW | Program counter of the issuing instruction |
| issue_level | input | LVLW | Current interrupt level |
| sw_brk | input | 1 | The issuing instruction is a wide software break |
| sw_brk_n | input | 1 | The issuing instruction is a narrow software break |
| dbg_allow | input | 1 | Debug events are permitted |
| evt_valid | output | 1 | A debug event is raised for the previous issue cycle |
| evt_cause | output | 6 | One-hot cause bits |
| evt_index | output | IDXW | Index of the breakpoint that matched |

## Verification
Two things can happen on the same issue: the counter can wrap, and an enabled breakpoint can match the instruction's address. The bench provokes this by presetting the counter to all ones with a nonzero counter level, arming breakpoint 0 on the program counter it then issues, and expecting cause 0x01 alone. Next it raises the issue level to the counter level, so the counter stops, and expects the breakpoint cause 0x02 on the same address. A second collision tests a counter write against counting: an instruction that issues with a simultaneous counter write must leave exactly the written value and must raise no event.

// File: rtl/ibsc_pkg.sv
package ibsc_pkg;
  localparam int SEL_W         = 3;
  localparam int SEL_ADDR_BASE = 4;
  localparam logic [SEL_W-1:0] SEL_ENA = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CNT = 3'd1;
  localparam logic [SEL_W-1:0] SEL_LVL = 3'd2;

  localparam int CAUSE_W = 6;
  localparam logic [CAUSE_W-1:0] CAUSE_STEP = 6'h01;
  localparam logic [CAUSE_W-1:0] CAUSE_IBRK = 6'h02;
  localparam logic [CAUSE_W-1:0] CAUSE_SWB  = 6'h08;
  localparam logic [CAUSE_W-1:0] CAUSE_SWBN = 6'h10;
endpackage

// File: rtl/ibsc_rst_sync.sv
module ibsc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/ibsc_regs.sv
module ibsc_regs
  import ibsc_pkg::*;
#(
  parameter int NUM_BP = 2,
  parameter int DW     = 32,
  parameter int LVLW   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [DW-1:0]              wr_data,
  input  logic                       cnt_adv,
  input  logic [DW-1:0]              cnt_adv_val,
  input  logic [SEL_W-1:0]           rd_sel,
  output logic [DW-1:0]              rd_data,
  output logic [NUM_BP-1:0]          ena_q,
  output logic [NUM_BP-1:0][DW-1:0]  addr_q,
  output logic [DW-1:0]              cnt_q,
  output logic [LVLW-1:0]            lvl_q,
  output logic                       cnt_wr
);
  logic              ena_we;
  logic [NUM_BP-1:0] ena_d;
  logic              lvl_we;
  logic [LVLW-1:0]   lvl_d;
  logic              cnt_en;
  logic [DW-1:0]     cnt_d;

  always_comb begin
    ena_we = wr_en && (wr_sel == SEL_ENA);
    ena_d  = wr_data[NUM_BP-1:0];
    lvl_we = wr_en && (wr_sel == SEL_LVL);
    lvl_d  = wr_data[LVLW-1:0];
    cnt_wr = wr_en && (wr_sel == SEL_CNT);
    cnt_en = cnt_wr || cnt_adv;
    cnt_d  = cnt_wr ? wr_data : cnt_adv_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
    end else if (ena_we) begin
      ena_q <= ena_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (lvl_we) begin
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < NUM_BP; i++) begin : g_addr
    logic addr_we;
    assign addr_we = wr_en && (wr_sel == SEL_W'(SEL_ADDR_BASE + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[i] <= '0;
      end else if (addr_we) begin
        addr_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_ENA: rd_data = {{(DW-NUM_BP){1'b0}}, ena_q};
      SEL_CNT: rd_data = cnt_q;
      SEL_LVL: rd_data = {{(DW-LVLW){1'b0}}, lvl_q};
      default: begin
        for (int i = 0; i < NUM_BP; i++) begin
          if (rd_sel == SEL_W'(SEL_ADDR_BASE + i)) rd_data = addr_q[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/ibsc_bp_match.sv
module ibsc_bp_match #(
  parameter int NUM_BP = 2,
  parameter int DW     = 32,
  parameter int IDXW   = 1
) (
  input  logic [NUM_BP-1:0]          ena,
  input  logic [NUM_BP-1:0][DW-1:0]  addr,
  input  logic [DW-1:0]              pc,
  output logic                       hit,
  output logic [IDXW-1:0]            idx
);
  logic [NUM_BP-1:0] eq;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
    assign eq[i] = ena[i] && (addr[i] == pc);
  end

  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = NUM_BP - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDXW'(i);
    end
  end
endmodule

// File: rtl/ibsc_step_ctr.sv
module ibsc_step_ctr #(
  parameter int DW   = 32,
  parameter int LVLW = 4
) (
  input  logic            issue,
  input  logic [LVLW-1:0] cur_lvl,
  input  logic [LVLW-1:0] cnt_lvl,
  input  logic [DW-1:0]   cnt_q,
  output logic            adv,
  output logic [DW-1:0]   adv_val,
  output logic            ovf
);
  logic counting;
  logic at_top;

  always_comb begin
    counting = issue && (cur_lvl < cnt_lvl);
    at_top   = &cnt_q;
    adv      = counting && !at_top;
    adv_val  = cnt_q + 1'b1;
    ovf      = counting && at_top;
  end
endmodule

// File: rtl/ibsc_top.sv
module ibsc_top
  import ibsc_pkg::*;
#(
  parameter int NUM_BP      = 2,
  parameter int DW          = 32,
  parameter int LVLW        = 4,
  parameter int DEBUG_LEVEL = 6,
  localparam int IDXW       = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sr_wr_en,
  input  logic [SEL_W-1:0]   sr_wr_sel,
  input  logic [DW-1:0]      sr_wr_data,
  input  logic [SEL_W-1:0]   sr_rd_sel,
  output logic [DW-1:0]      sr_rd_data,
  input  logic               issue_valid,
  input  logic [DW-1:0]      issue_pc,
  input  logic [LVLW-1:0]    issue_level,
  input  logic               sw_brk,
  input  logic               sw_brk_n,
  input  logic               dbg_allow,
  output logic               evt_valid,
  output logic [CAUSE_W-1:0] evt_cause,
  output logic [IDXW-1:0]    evt_index
);
  localparam logic [LVLW-1:0] DBG_LVL = LVLW'(DEBUG_LEVEL);

  logic                      rst_sync_n;
  logic [NUM_BP-1:0]         ena_q;
  logic [NUM_BP-1:0][DW-1:0] addr_q;
  logic [DW-1:0]             cnt_q;
  logic [LVLW-1:0]           lvl_q;
  logic                      cnt_wr;
  logic                      cnt_adv;
  logic [DW-1:0]             cnt_adv_val;
  logic                      cnt_ovf;
  logic                      bp_hit;
  logic [IDXW-1:0]           bp_idx;
  logic                      cnt_issue;
  logic                      gate;
  logic                      ev_d;
  logic [CAUSE_W-1:0]        cause_d;
  logic [IDXW-1:0]           idx_d;

  ibsc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ibsc_regs #(.NUM_BP(NUM_BP), .DW(DW), .LVLW(LVLW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (sr_wr_en),
    .wr_sel      (sr_wr_sel),
    .wr_data     (sr_wr_data),
    .cnt_adv     (cnt_adv),
    .cnt_adv_val (cnt_adv_val),
    .rd_sel      (sr_rd_sel),
    .rd_data     (sr_rd_data),
    .ena_q       (ena_q),
    .addr_q      (addr_q),
    .cnt_q       (cnt_q),
    .lvl_q       (lvl_q),
    .cnt_wr      (cnt_wr)
  );

  ibsc_bp_match #(.NUM_BP(NUM_BP), .DW(DW), .IDXW(IDXW)) u_match (
    .ena  (ena_q),
    .addr (addr_q),
    .pc   (issue_pc),
    .hit  (bp_hit),
    .idx  (bp_idx)
  );

  // a counter write from the issuing instruction replaces its own count
  assign cnt_issue = issue_valid && !cnt_wr;

  ibsc_step_ctr #(.DW(DW), .LVLW(LVLW)) u_ctr (
    .issue   (cnt_issue),
    .cur_lvl (issue_level),
    .cnt_lvl (lvl_q),
    .cnt_q   (cnt_q),
    .adv     (cnt_adv),
    .adv_val (cnt_adv_val),
    .ovf     (cnt_ovf)
  );

  always_comb begin
    gate    = dbg_allow && (issue_level < DBG_LVL);
    ev_d    = 1'b0;
    cause_d = '0;
    idx_d   = '0;
    if (issue_valid && gate) begin
      if (cnt_ovf) begin
        ev_d    = 1'b1;
        cause_d = CAUSE_STEP;
      end else if (bp_hit) begin
        ev_d    = 1'b1;
        cause_d = CAUSE_IBRK;
        idx_d   = bp_idx;
      end else if (sw_brk) begin
        ev_d    = 1'b1;
        cause_d = CAUSE_SWB;
      end else if (sw_brk_n) begin
        ev_d    = 1'b1;
        cause_d = CAUSE_SWBN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      evt_valid <= 1'b0;
      evt_cause <= '0;
      evt_index <= '0;
    end else begin
      evt_valid <= ev_d;
      evt_cause <= cause_d;
      evt_index <= idx_d;
    end
  end
endmodule

// File: rtl/ibsc_chk.sv
module ibsc_chk
  import ibsc_pkg::*;
#(
  parameter int DW          = 32,
  parameter int LVLW        = 4,
  parameter int DEBUG_LEVEL = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               issue_valid,
  input logic [LVLW-1:0]    issue_level,
  input logic               dbg_allow,
  input logic               cnt_wr,
  input logic [DW-1:0]      wr_data,
  input logic [DW-1:0]      cnt_q,
  input logic [LVLW-1:0]    lvl_q,
  input logic               evt_valid,
  input logic [CAUSE_W-1:0] evt_cause
);
  localparam logic [LVLW-1:0] DBG_LVL = LVLW'(DEBUG_LEVEL);

  // R8
  evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(issue_valid && dbg_allow && (issue_level < DBG_LVL)));

  // R9
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> ($countones(evt_cause) == 1));

  // R9
  cause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |-> (evt_cause == '0));

  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_cause == CAUSE_STEP)) |-> ($past(&cnt_q) && $stable(cnt_q)));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue_valid && !cnt_wr && (issue_level < lvl_q) && !(&cnt_q))
      |-> (cnt_q == DW'($past(cnt_q) + 1'b1)));

  // R6
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cnt_wr && !(issue_valid && (issue_level < lvl_q))) |-> $stable(cnt_q));

  // R10
  cnt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_wr) |-> (cnt_q == $past(wr_data)));
endmodule

bind ibsc_top ibsc_chk #(.DW(DW), .LVLW(LVLW), .DEBUG_LEVEL(DEBUG_LEVEL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .issue_valid (issue_valid),
  .issue_level (issue_level),
  .dbg_allow   (dbg_allow),
  .cnt_wr      (cnt_wr),
  .wr_data     (sr_wr_data),
  .cnt_q       (cnt_q),
  .lvl_q       (lvl_q),
  .evt_valid   (evt_valid),
  .evt_cause   (evt_cause)
);

// File: tb/sim_ibsc_top.sv
module sim_ibsc_top;
  localparam time TCK = 20ns;

  logic        clk;
  logic        rst_n;
  logic        sr_wr_en;
  logic [2:0]  sr_wr_sel;
  logic [31:0] sr_wr_data;
  logic [2:0]  sr_rd_sel;
  logic [31:0] sr_rd_data;
  logic        issue_valid;
  logic [31:0] issue_pc;
  logic [3:0]  issue_level;
  logic        sw_brk;
  logic        sw_brk_n;
  logic        dbg_allow;
  logic        evt_valid;
  logic [5:0]  evt_cause;
  logic [0:0]  evt_index;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic       v;
    logic [5:0] c;
    logic [0:0] idx;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  ibsc_top u0 (
    .clk(clk), .rst_n(rst_n),
    .sr_wr_en(sr_wr_en), .sr_wr_sel(sr_wr_sel), .sr_wr_data(sr_wr_data),
    .sr_rd_sel(sr_rd_sel), .sr_rd_data(sr_rd_data),
    .issue_valid(issue_valid), .issue_pc(issue_pc), .issue_level(issue_level),
    .sw_brk(sw_brk), .sw_brk_n(sw_brk_n), .dbg_allow(dbg_allow),
    .evt_valid(evt_valid), .evt_cause(evt_cause), .evt_index(evt_index)
  );

  initial clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: results for inputs driven at a falling edge appear after the next rising edge
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk({e.tag, " valid"}, {31'b0, evt_valid}, {31'b0, e.v});
      chk({e.tag, " cause"}, {26'b0, evt_cause}, {26'b0, e.c});
      chk({e.tag, " index"}, {31'b0, evt_index}, {31'b0, e.idx});
    end
  end

  task automatic sr_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    sr_wr_en = 1'b1; sr_wr_sel = sel; sr_wr_data = data;
    @(negedge clk);
    sr_wr_en = 1'b0;
  endtask

  task automatic sr_check(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    sr_rd_sel = sel;
    #1;
    chk(tag, sr_rd_data, exp);
  endtask

  task automatic issue(input logic [31:0] pc, input logic [3:0] lvl, input logic b,
                       input logic bn, input logic ev, input logic [5:0] c,
                       input logic idx, input string tag,
                       input logic wr = 1'b0, input logic [31:0] wd = 32'h0);
    exp_t e;
    @(negedge clk);
    issue_valid = 1'b1; issue_pc = pc; issue_level = lvl; sw_brk = b; sw_brk_n = bn;
    if (wr) begin
      sr_wr_en = 1'b1; sr_wr_sel = 3'd1; sr_wr_data = wd;
    end
    e.v = ev; e.c = c; e.idx = idx; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    issue_valid = 1'b0; sw_brk = 1'b0; sw_brk_n = 1'b0; sr_wr_en = 1'b0;
  endtask

  initial begin
    #(TCK * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sr_wr_en = 1'b0; sr_wr_sel = 3'd0; sr_wr_data = 32'h0;
    sr_rd_sel = 3'd0; issue_valid = 1'b0; issue_pc = 32'h0; issue_level = 4'd0;
    sw_brk = 1'b0; sw_brk_n = 1'b0; dbg_allow = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 evt_valid", {31'b0, evt_valid}, 32'h0);
    sr_check(3'd0, 32'h0, "R1 enable");
    sr_check(3'd1, 32'h0, "R1 counter");
    sr_check(3'd2, 32'h0, "R1 level");

    // R2 enable mask width
    sr_write(3'd0, 32'hFFFF_FFFF);
    sr_check(3'd0, 32'h3, "R2 enable mask");
    sr_write(3'd0, 32'h0);

    // R3 level width
    sr_write(3'd2, 32'hFFFF_FF37);
    sr_check(3'd2, 32'h7, "R3 level bits");
    sr_write(3'd2, 32'h0);

    // R4 / R5 breakpoints
    sr_write(3'd4, 32'h0000_1000);
    sr_write(3'd5, 32'h0000_2000);
    sr_check(3'd5, 32'h0000_2000, "R4 addr1 readback");
    issue(32'h1000, 4'd0, 0, 0, 0, 6'h00, 0, "R5 all disabled");
    sr_write(3'd0, 32'h2);
    issue(32'h1000, 4'd0, 0, 0, 0, 6'h00, 0, "R5 bp0 disabled");
    issue(32'h2000, 4'd0, 0, 0, 1, 6'h02, 1, "R4 bp1 hit");
    issue(32'h2004, 4'd0, 0, 0, 0, 6'h00, 0, "R4 no match");
    sr_write(3'd5, 32'h0000_1000);
    sr_write(3'd0, 32'h3);
    issue(32'h1000, 4'd0, 0, 0, 1, 6'h02, 0, "R4 lowest index");

    // R8 gating
    issue(32'h1000, 4'd6, 0, 0, 0, 6'h00, 0, "R8 level at debug level");
    issue(32'h1000, 4'd5, 0, 0, 1, 6'h02, 0, "R8 level below debug level");
    dbg_allow = 1'b0;
    issue(32'h1000, 4'd0, 0, 0, 0, 6'h00, 0, "R8 debug not allowed");
    dbg_allow = 1'b1;

    // R9 software break and priority
    sr_write(3'd0, 32'h0);
    issue(32'h3000, 4'd0, 1, 0, 1, 6'h08, 0, "R9 wide break");
    issue(32'h3000, 4'd0, 0, 1, 1, 6'h10, 0, "R9 narrow break");
    sr_write(3'd0, 32'h1);
    issue(32'h1000, 4'd0, 1, 0, 1, 6'h02, 0, "R9 breakpoint over break");
    sr_write(3'd0, 32'h0);

    // R11 preset -2, level 1
    sr_write(3'd1, 32'hFFFF_FFFE);
    sr_write(3'd2, 32'h1);
    issue(32'h4000, 4'd0, 0, 0, 0, 6'h00, 0, "R11 first counted");
    issue(32'h4004, 4'd0, 0, 0, 1, 6'h01, 0, "R11 second counted");
    // R7 hold on wrap
    sr_check(3'd1, 32'hFFFF_FFFF, "R7 counter held");
    issue(32'h4008, 4'd0, 0, 0, 1, 6'h01, 0, "R7 repeated overflow");
    sr_check(3'd1, 32'hFFFF_FFFF, "R7 counter still held");

    // R6 counting and level gate
    sr_write(3'd1, 32'd5);
    sr_write(3'd2, 32'd3);
    issue(32'h5000, 4'd2, 0, 0, 0, 6'h00, 0, "R6 counted");
    issue(32'h5004, 4'd3, 0, 0, 0, 6'h00, 0, "R6 not counted");
    sr_check(3'd1, 32'd6, "R6 counter value");

    // R8 counter runs above debug level, events stay off
    sr_write(3'd1, 32'd0);
    sr_write(3'd2, 32'd8);
    issue(32'h5008, 4'd7, 0, 0, 0, 6'h00, 0, "R8 count above debug level");
    sr_check(3'd1, 32'd1, "R8 counter advanced");
    sr_write(3'd1, 32'hFFFF_FFFF);
    sr_write(3'd2, 32'd1);
    dbg_allow = 1'b0;
    issue(32'h500C, 4'd0, 0, 0, 0, 6'h00, 0, "R8 overflow suppressed");
    dbg_allow = 1'b1;
    sr_check(3'd1, 32'hFFFF_FFFF, "R8 counter held while suppressed");

    // R10 write collides with issue
    issue(32'h6000, 4'd0, 0, 0, 0, 6'h00, 0, "R10 write wins", 1'b1, 32'd10);
    sr_check(3'd1, 32'd10, "R10 written value");
    issue(32'h6004, 4'd0, 0, 0, 0, 6'h00, 0, "R10 next counts");
    sr_check(3'd1, 32'd11, "R10 after next");

    // R9 counter over breakpoint in the same cycle
    sr_write(3'd4, 32'h0000_7000);
    sr_write(3'd0, 32'h1);
    sr_write(3'd1, 32'hFFFF_FFFF);
    issue(32'h7000, 4'd0, 0, 0, 1, 6'h01, 0, "R9 counter over breakpoint");
    issue(32'h7000, 4'd1, 0, 0, 1, 6'h02, 0, "R9 breakpoint when not counting");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule